// File: doc/BRIEF.md
# Coherent Clock Register Buffer

This block sits between a set of free-running timekeeping counters and the register interface of a serial bus slave. The host never touches the counters directly. It reads and writes a bank of holding bytes, one per clock register (sub-seconds, seconds, minutes, century/hours, day, date, month and year at addresses 0x00 to 0x07). When a read transaction opens, every live counter value is copied into the bank in a single cycle. All bytes the host then reads therefore come from the same instant, even if the counters roll over during the transfer.

Host writes collect in the bank and set a pending-update flag. When the transaction closes, the whole bank goes to the counters in one bulk load, whether or not each byte was written. A halt bit is forced to 1 when power fails. It captures the time of power-down and stops later reads from refreshing the bank, so software can read when the outage began. Once software clears the halt bit, reads return the present time again. A clock write made while the bit is still set loads the old, edited power-down time back into the counters.

Top module: `clkreg_shadow`

## Requirements
- R1: The first `rd_start` pulse after a `bus_stop` (or after reset) copies all eight `live_cnt` bytes into the bank at one clock edge, provided the halt bit is 0. Further `rd_start` pulses before the next `bus_stop` do not copy again. Counter changes after the copy are not visible in `rd_data`.
- R2: A write with `wr_en` high to address 0..7 replaces that bank byte at the clock edge, and `rd_data` returns it from the next cycle. `load_strobe` stays low until a `bus_stop`.
- R3: A write to any address from 8 to 31 other than the halt register does not set the pending-update flag, so a later `bus_stop` gives no `load_strobe`. Such addresses read as 0x00.
- R4: A `bus_stop` raises `load_strobe` for exactly one cycle, in the cycle after the edge, in either of two cases: the pending-update flag is set, or a clock-address write arrives in the same cycle. `load_data` then holds all eight bank bytes, byte i in bits [8i+7:8i], including any write made in that same cycle. The flag is then clear, so the next `bus_stop` gives no strobe.
- R5: The halt bit is bit 6 of address 0x0C. It reads as 0x40 when set and 0x00 when clear, with every other bit reading 0. A write to 0x0C loads it from `wr_data[6]`. It is 1 after reset, and `halt` mirrors it.
- R6: A rising edge of `pwr_fail` copies `live_cnt` into the bank and sets the halt bit at the same clock edge. A host write in that same cycle is discarded: it changes no byte and sets no flag.
- R7: While the halt bit is 1, `rd_start` does not refresh the bank, so reads keep returning the captured bytes while the counters move on.
- R8: After the halt bit is written to 0, the next opening `rd_start` returns the present `live_cnt` values.
- R9: A clock-address write made while the halt bit is 1 followed by `bus_stop` puts the captured power-down bytes, with the written byte replaced, on `load_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_start | input | 1 | Pulse: a read transaction begins |
| bus_stop | input | 1 | Pulse: the current transaction ends |
| wr_en | input | 1 | Write strobe for `wr_data` at `reg_addr` |
| reg_addr | input | 5 | Register address |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data at `reg_addr` (combinational) |
| live_cnt | input | 64 | Live counter bytes, byte i in bits [8i+7:8i] |
| pwr_fail | input | 1 | Power-fail level; its rising edge triggers capture |
| load_strobe | output | 1 | One-cycle bulk load request to the counters |
| load_data | output | 64 | Values for the counters, same layout as `live_cnt` |
| halt | output | 1 | Current halt bit |

## Verification
Two pairs of events can fall on the same edge. The first pair is a clock-address write and the closing `bus_stop`. The bench drives `wr_en` and `bus_stop` in the same cycle and expects the written byte to appear in the strobed `load_data`. The second pair is a power-fail rising edge and a host write. The bench raises `pwr_fail` in the same cycle as a write to address 2, then checks three things: the bank holds the live byte, not the written one; the halt bit is set; and the next `bus_stop` gives no strobe.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    // Control bundle the sequencer hands to the holding bank each cycle
    typedef struct packed {
        logic cap;     // power-fail capture of live counters
        logic snap;    // opening-read snapshot of live counters
        logic clk_wr;  // host write aimed at a clock byte
    } bank_ctl_t;

    typedef enum logic [1:0] {
        ADDR_CLOCK = 2'd0,
        ADDR_HALT  = 2'd1,
        ADDR_OTHER = 2'd2
    } addr_class_e;

    function automatic addr_class_e classify_addr(
        input int unsigned addr,
        input int unsigned num_clk,
        input int unsigned halt_addr
    );
        if (addr < num_clk)
            return ADDR_CLOCK;
        else if (addr == halt_addr)
            return ADDR_HALT;
        else
            return ADDR_OTHER;
    endfunction

endpackage

// File: rtl/clkreg_ctrl.sv
import clkreg_pkg::*;

module clkreg_ctrl #(
    parameter int NUM_CLK_REGS = 8,
    parameter int ADDR_W       = 5,
    parameter int HALT_ADDR    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_start,
    input  logic              bus_stop,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              ht_wbit,
    input  logic              pwr_fail,
    output bank_ctl_t         ctl,
    output logic              fire,
    output logic              halt
);

    logic        pf_q;
    logic        in_xfer;
    logic        wflag;
    logic        halt_q;
    logic        pf_rise;
    addr_class_e cls;

    assign cls     = classify_addr(32'(reg_addr), NUM_CLK_REGS, HALT_ADDR);
    assign pf_rise = pwr_fail && !pf_q;

    always_comb begin
        ctl        = '0;
        ctl.cap    = pf_rise;
        ctl.clk_wr = wr_en && (cls == ADDR_CLOCK) && !pf_rise;
        ctl.snap   = rd_start && !in_xfer && !halt_q && !pf_rise;
    end

    assign fire = bus_stop && (wflag || ctl.clk_wr);
    assign halt = halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_q    <= 1'b0;
            in_xfer <= 1'b0;
            wflag   <= 1'b0;
            halt_q  <= 1'b1;
        end else begin
            pf_q <= pwr_fail;

            if (bus_stop)
                in_xfer <= 1'b0;
            else if (rd_start)
                in_xfer <= 1'b1;

            if (bus_stop)
                wflag <= 1'b0;
            else if (ctl.clk_wr)
                wflag <= 1'b1;

            if (pf_rise)
                halt_q <= 1'b1;
            else if (wr_en && (cls == ADDR_HALT))
                halt_q <= ht_wbit;
        end
    end

    AST_FLAG_CLEARED_AT_STOP: assert property (@(posedge clk) disable iff (rst)
        bus_stop |=> !wflag); // R4

    AST_OTHER_ADDR_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!wflag && wr_en && (reg_addr >= ADDR_W'(NUM_CLK_REGS))) |=> !wflag); // R3

endmodule

// File: rtl/clkreg_bank.sv
import clkreg_pkg::*;

module clkreg_bank #(
    parameter int NUM_CLK_REGS = 8,
    parameter int DATA_W       = 8,
    parameter int IDX_W        = 3
) (
    input  logic                               clk,
    input  logic                               rst,
    input  bank_ctl_t                          ctl,
    input  logic [IDX_W-1:0]                   wr_idx,
    input  logic [DATA_W-1:0]                  wr_data,
    input  logic [NUM_CLK_REGS-1:0][DATA_W-1:0] live,
    output logic [NUM_CLK_REGS-1:0][DATA_W-1:0] buf_q,
    output logic [NUM_CLK_REGS-1:0][DATA_W-1:0] buf_nxt
);

    for (genvar g = 0; g < NUM_CLK_REGS; g++) begin : g_byte
        always_comb begin
            buf_nxt[g] = buf_q[g];
            if (ctl.cap || ctl.snap)
                buf_nxt[g] = live[g];
            if (ctl.clk_wr && (wr_idx == IDX_W'(g)))
                buf_nxt[g] = wr_data;
        end

        always_ff @(posedge clk) begin
            if (rst)
                buf_q[g] <= '0;
            else
                buf_q[g] <= buf_nxt[g];
        end
    end

    AST_CAPTURE_TAKES_LIVE: assert property (@(posedge clk) disable iff (rst)
        ctl.cap |=> (buf_q == $past(live))); // R6

endmodule

// File: rtl/clkreg_loadout.sv
module clkreg_loadout #(
    parameter int VEC_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic [VEC_W-1:0] vec_in,
    output logic             load_strobe,
    output logic [VEC_W-1:0] load_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            load_strobe <= 1'b0;
            load_data   <= '0;
        end else begin
            load_strobe <= fire;
            if (fire)
                load_data <= vec_in;
        end
    end

endmodule

// File: rtl/clkreg_shadow.sv
import clkreg_pkg::*;

module clkreg_shadow #(
    parameter int NUM_CLK_REGS = 8,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 5,
    parameter int HALT_ADDR    = 12,
    parameter int HALT_BIT     = 6
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_start,
    input  logic                             bus_stop,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [DATA_W-1:0]                rd_data,
    input  logic [NUM_CLK_REGS*DATA_W-1:0]   live_cnt,
    input  logic                             pwr_fail,
    output logic                             load_strobe,
    output logic [NUM_CLK_REGS*DATA_W-1:0]   load_data,
    output logic                             halt
);

    localparam int IDX_W = (NUM_CLK_REGS > 1) ? $clog2(NUM_CLK_REGS) : 1;
    localparam int VEC_W = NUM_CLK_REGS * DATA_W;

    bank_ctl_t                             ctl;
    logic                                  fire;
    logic [NUM_CLK_REGS-1:0][DATA_W-1:0]   live_arr;
    logic [NUM_CLK_REGS-1:0][DATA_W-1:0]   buf_q;
    logic [NUM_CLK_REGS-1:0][DATA_W-1:0]   buf_nxt;
    addr_class_e                           rd_cls;

    assign live_arr = live_cnt;

    clkreg_ctrl #(
        .NUM_CLK_REGS (NUM_CLK_REGS),
        .ADDR_W       (ADDR_W),
        .HALT_ADDR    (HALT_ADDR)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rd_start (rd_start),
        .bus_stop (bus_stop),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .ht_wbit  (wr_data[HALT_BIT]),
        .pwr_fail (pwr_fail),
        .ctl      (ctl),
        .fire     (fire),
        .halt     (halt)
    );

    clkreg_bank #(
        .NUM_CLK_REGS (NUM_CLK_REGS),
        .DATA_W       (DATA_W),
        .IDX_W        (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .wr_idx  (reg_addr[IDX_W-1:0]),
        .wr_data (wr_data),
        .live    (live_arr),
        .buf_q   (buf_q),
        .buf_nxt (buf_nxt)
    );

    clkreg_loadout #(
        .VEC_W (VEC_W)
    ) u_load (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .vec_in      (buf_nxt),
        .load_strobe (load_strobe),
        .load_data   (load_data)
    );

    // Read path: clock bytes from the bank, halt register, zero elsewhere
    assign rd_cls = classify_addr(32'(reg_addr), NUM_CLK_REGS, HALT_ADDR);

    always_comb begin
        rd_data = '0;
        case (rd_cls)
            ADDR_CLOCK: rd_data = buf_q[reg_addr[IDX_W-1:0]];
            ADDR_HALT:  rd_data[HALT_BIT] = halt;
            default:    rd_data = '0;
        endcase
    end

    AST_LOAD_ONLY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        load_strobe |-> $past(bus_stop)); // R4

    AST_HALT_ON_POWER_FAIL: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_fail) |=> halt); // R6

    AST_BANK_FROZEN_WHILE_HALTED: assert property (@(posedge clk) disable iff (rst)
        (halt && !ctl.cap && !ctl.clk_wr) |=> $stable(buf_q)); // R7

endmodule

// File: tb/tb_clkreg_shadow.sv
module tb_clkreg_shadow;

    logic        clk = 1'b0;
    logic        rst;
    logic        rd_start, bus_stop, wr_en, pwr_fail;
    logic [4:0]  reg_addr;
    logic [7:0]  wr_data;
    logic [7:0]  rd_data;
    logic [7:0][7:0] lv;
    logic [63:0] live_cnt;
    logic        load_strobe;
    logic [63:0] load_data;
    logic        halt;

    logic [7:0][7:0] eb;
    int nvec  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    assign live_cnt = lv;

    always #10 clk = ~clk;

    clkreg_shadow dut (
        .clk         (clk),
        .rst         (rst),
        .rd_start    (rd_start),
        .bus_stop    (bus_stop),
        .wr_en       (wr_en),
        .reg_addr    (reg_addr),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .live_cnt    (live_cnt),
        .pwr_fail    (pwr_fail),
        .load_strobe (load_strobe),
        .load_data   (load_data),
        .halt        (halt)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic fill_live(input int seed);
        for (int i = 0; i < 8; i++)
            lv[i] = 8'(seed * 37 + i * 11 + 5);
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 8; i++) begin
            reg_addr = 5'(i);
            #1;
            chk(tag, {56'd0, rd_data}, {56'd0, eb[i]});
        end
    endtask

    task automatic do_write(input int a, input logic [7:0] d);
        reg_addr = 5'(a);
        wr_data  = d;
        wr_en    = 1'b1;
        step();
        wr_en    = 1'b0;
    endtask

    task automatic do_rdstart();
        rd_start = 1'b1;
        step();
        rd_start = 1'b0;
    endtask

    task automatic do_stop(input string tag, input bit exp_strobe, input logic [63:0] exp_data);
        bus_stop = 1'b1;
        step();
        bus_stop = 1'b0;
        chk(tag, {63'd0, load_strobe}, {63'd0, exp_strobe});
        if (exp_strobe)
            chk(tag, load_data, exp_data);
        step();
        chk(tag, {63'd0, load_strobe}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rd_start = 0; bus_stop = 0; wr_en = 0; pwr_fail = 0;
        reg_addr = '0; wr_data = '0; lv = '0; eb = '0;
        repeat (3) step();
        rst = 1'b0;
        step();

        // R5 reset state: halt set, halt register reads 0x40
        chk("R5 reset halt", {63'd0, halt}, 64'd1);
        reg_addr = 5'd12; #1;
        chk("R5 reset halt reg", {56'd0, rd_data}, 64'h40);
        chk("R4 reset strobe", {63'd0, load_strobe}, 64'd0);
        rd_all("R1 reset bank");

        // R5 only bit 6 is stored
        do_write(12, 8'hFF);
        reg_addr = 5'd12; #1;
        chk("R5 halt reg bits", {56'd0, rd_data}, 64'h40);
        do_write(12, 8'hBF);
        chk("R5 halt cleared", {63'd0, halt}, 64'd0);
        reg_addr = 5'd12; #1;
        chk("R5 halt reg clear", {56'd0, rd_data}, 64'h00);
        do_stop("R3 halt write no flag", 1'b0, '0);

        // R1 snapshot and hold during transaction
        fill_live(1); eb = lv;
        do_rdstart();
        fill_live(2);
        rd_all("R1 snapshot");
        do_rdstart();
        rd_all("R1 repeated start");
        do_stop("R1 read stop", 1'b0, '0);
        eb = lv;
        do_rdstart();
        rd_all("R1 next read");
        do_stop("R1 next stop", 1'b0, '0);

        // R2 / R4 sweep over every clock byte
        for (int a = 0; a < 8; a++) begin
            fill_live(10 + a); eb = lv;
            do_rdstart();
            fill_live(20 + a);
            do_write(a, 8'(8'hA0 + a * 3));
            eb[a] = 8'(8'hA0 + a * 3);
            reg_addr = 5'(a); #1;
            chk("R2 write readback", {56'd0, rd_data}, {56'd0, eb[a]});
            chk("R2 no early strobe", {63'd0, load_strobe}, 64'd0);
            do_stop("R4 bulk load", 1'b1, eb);
            do_stop("R4 flag cleared", 1'b0, '0);
        end

        // R3 sweep over non-clock addresses
        for (int a = 8; a < 32; a++) begin
            if (a != 12) begin
                do_write(a, 8'h5A);
                reg_addr = 5'(a); #1;
                chk("R3 other reads zero", {56'd0, rd_data}, 64'd0);
                do_stop("R3 no flag", 1'b0, '0);
            end
        end
        rd_all("R3 bank untouched");

        // R4 write and stop in the same cycle
        reg_addr = 5'd3; wr_data = 8'hC3; wr_en = 1'b1; bus_stop = 1'b1;
        step();
        wr_en = 1'b0; bus_stop = 1'b0;
        eb[3] = 8'hC3;
        chk("R4 same-cycle strobe", {63'd0, load_strobe}, 64'd1);
        chk("R4 same-cycle data", load_data, eb);
        step();
        chk("R4 same-cycle pulse", {63'd0, load_strobe}, 64'd0);

        // R6 power fail with a colliding write
        fill_live(40);
        pwr_fail = 1'b1; reg_addr = 5'd2; wr_data = 8'h77; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
        eb = lv;
        chk("R6 halt set", {63'd0, halt}, 64'd1);
        rd_all("R6 captured");
        do_stop("R6 write discarded", 1'b0, '0);

        // R7 halted reads keep power-down time
        fill_live(41);
        do_rdstart();
        rd_all("R7 frozen");
        do_stop("R7 stop", 1'b0, '0);
        pwr_fail = 1'b0;

        // R9 clock write while halted reloads stale time
        do_write(0, 8'h11);
        eb[0] = 8'h11;
        do_stop("R9 stale load", 1'b1, eb);
        chk("R9 halt still set", {63'd0, halt}, 64'd1);

        // R8 clear halt then read present time
        do_write(12, 8'h00);
        do_stop("R8 clear halt", 1'b0, '0);
        fill_live(50); eb = lv;
        do_rdstart();
        fill_live(51);
        rd_all("R8 present time");
        do_stop("R8 stop", 1'b0, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule